// File: doc/BRIEF.md
# Shared-Buffer SPI Target with Block Read and Write

This block lets an external SPI master read and write a word-addressed buffer on the local side. Every transaction opens, after chip select goes low, with a 32-bit header. The command sits in its top four bits and a 28-bit word address fills the rest. The header is followed by any number of 32-bit data words. A write command stores each complete word at the current address. A read command sends back words taken from consecutive addresses. After each word the address moves up by one.

The SPI pins are brought into the system clock domain through synchronizer chains. Each SPI edge is then handled as a single-cycle event. All four SPI clock modes are available through a 2-bit mode input. The local side sees a plain synchronous memory port with single-cycle write and read strobes, and read data is expected one cycle after the read strobe. When chip select rises, the transaction in progress is abandoned and the transmit path is cleared. If that transaction was a valid read or write, a done pulse is raised along with the number of whole words moved. For read-back to keep up, the system clock should run at least eight times faster than SCLK.

Top module: `spi_mem_bridge`

## Requirements
- R1: The first 32 bits after chip select falls form the header, sent MSB first. Bits 31..28 hold the command and bits 27..0 hold the starting word address, which is presented unchanged on `mem_addr`.
- R2: Command 4'h5 (write) stores each received 32-bit word, MSB first, with one `mem_we` pulse. The first word goes to the header address and each later word goes to the next address up.
- R3: During a write, trailing bits that do not fill a whole 32-bit word before chip select rises produce no memory write.
- R4: Command 4'h4 (read) drives exactly 8 zero bits on MISO after the header. It then sends 32-bit words MSB first, taken from the header address and the addresses above it.
- R5: Any other command value produces no memory write and no done pulse, and MISO stays zero for the whole transaction.
- R6: A chip-select rise at any bit position abandons the current command. The next transaction then starts with a fresh header.
- R7: MISO is always driven. It is zero while chip select is high and during every header, and the first transaction after an aborted read shows no leftover data.
- R8: The `spi_mode` input selects CPOL (bit 1) and CPHA (bit 0). All four combinations read and write correctly.
- R9: A valid read or write transaction ends with a one-cycle `xfer_done` pulse once chip select rises. This includes a read that is aborted before any word completes.
- R10: `mem_we` and `mem_re` are single-cycle strobes that never occur together, and `mem_rdata` is taken one cycle after `mem_re`.
- R11: `xfer_words` carries, alongside `xfer_done`, the number of complete 32-bit data words written or read in that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_mode | input | 2 | Bit 1 = CPOL, bit 0 = CPHA |
| spi_sclk | input | 1 | SPI clock from master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master, always driven |
| mem_we | output | 1 | Buffer write strobe |
| mem_re | output | 1 | Buffer read strobe |
| mem_addr | output | 28 | Buffer word address |
| mem_wdata | output | 32 | Buffer write data |
| mem_rdata | input | 32 | Buffer read data, valid one cycle after `mem_re` |
| xfer_done | output | 1 | One-cycle end-of-transaction pulse |
| xfer_words | output | 16 | Whole words moved, valid with `xfer_done` |

## Verification
Writes and reads are tried in every clock mode. This separates a design that samples on the correct edge from one that is right in only one polarity or phase. Writes are also tried with extra trailing bits, and reads with a partial final word, which shows whether the word counter and write strobe stop at whole-word boundaries. An unknown command aimed at an address that already holds data, followed by reading it back, shows whether ignored data reaches memory. Chip select is also cut off inside a header, inside the dummy gap of a read and inside a data word. The transactions that follow check header realignment and the clearing of the transmit path.

// File: rtl/spi_mem_bridge_pkg.sv
package spi_mem_bridge_pkg;
   localparam int CMD_W  = 4;
   localparam int ADDR_W = 28;
   localparam int WORD_W = CMD_W + ADDR_W;

   localparam logic [CMD_W-1:0] OP_WRITE = 4'h5;
   localparam logic [CMD_W-1:0] OP_READ  = 4'h4;

   typedef enum logic [2:0] {
      ST_HDR,
      ST_WR,
      ST_RD_PAD,
      ST_RD,
      ST_SKIP
   } xfer_st_e;
endpackage

// File: rtl/spi_mem_bridge_sync.sv
module spi_mem_bridge_sync #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] spi_mode,
   input  logic       sclk,
   input  logic       cs_n,
   input  logic       mosi,
   output logic       cs_act,
   output logic       cs_end,
   output logic       smp,
   output logic       shf,
   output logic       mosi_s
);
   localparam int NSIG = 3;
   localparam logic [NSIG-1:0] RST_VAL = 3'b100;   // {cs_n, sclk, mosi}

   logic [NSIG-1:0] raw;
   logic [NSIG-1:0] synced;
   logic            sclk_q, cs_q;
   logic            rise, fall, lead_is_fall;

   assign raw = {cs_n, sclk, mosi};

   for (genvar g = 0; g < NSIG; g++) begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_q   <= 1'b1;
      end else begin
         sclk_q <= synced[1];
         cs_q   <= synced[2];
      end
   end

   assign mosi_s       = synced[0];
   assign cs_act       = ~synced[2];
   assign cs_end       = synced[2] & ~cs_q;
   assign rise         = synced[1] & ~sclk_q;
   assign fall         = ~synced[1] & sclk_q;
   assign lead_is_fall = spi_mode[1] ^ spi_mode[0];
   assign smp          = cs_act & (lead_is_fall ? fall : rise);
   assign shf          = cs_act & (lead_is_fall ? rise : fall);
endmodule

// File: rtl/spi_mem_bridge_core.sv
module spi_mem_bridge_core
   import spi_mem_bridge_pkg::*;
#(
   parameter int DUMMY_BITS = 8,
   parameter int CNT_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              cs_end,
   input  logic              smp,
   input  logic              shf,
   input  logic              mosi_s,
   output logic              miso,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              done,
   output logic [CNT_W-1:0]  done_words
);
   localparam int BIT_W = $clog2(WORD_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
   localparam logic [BIT_W-1:0] PAD_LAST = BIT_W'(DUMMY_BITS - 1);

   xfer_st_e          st;
   logic [BIT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] rx_sh, rx_next, tx_sh, tx_buf;
   logic [ADDR_W-1:0] addr;
   logic [CNT_W-1:0]  words;
   logic              pend, load, rd_cap;

   assign rx_next = {rx_sh[WORD_W-2:0], mosi_s};
   assign miso    = tx_sh[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_HDR;  bit_cnt <= '0;  rx_sh <= '0;  tx_sh <= '0;  tx_buf <= '0;
         addr <= '0;  words <= '0;  pend <= 1'b0;  load <= 1'b0;  rd_cap <= 1'b0;
         mem_we <= 1'b0;  mem_re <= 1'b0;  mem_addr <= '0;  mem_wdata <= '0;
         done <= 1'b0;  done_words <= '0;
      end else begin
         mem_we <= 1'b0;
         mem_re <= 1'b0;
         done   <= 1'b0;
         rd_cap <= mem_re;
         if (rd_cap) tx_buf <= mem_rdata;
         if (cs_end && st != ST_HDR && st != ST_SKIP) begin
            done       <= 1'b1;
            done_words <= words;
         end
         if (!cs_act) begin
            st <= ST_HDR;  bit_cnt <= '0;  tx_sh <= '0;  tx_buf <= '0;
            words <= '0;  pend <= 1'b0;  load <= 1'b0;
         end else begin
            if (smp) begin
               rx_sh   <= rx_next;
               bit_cnt <= bit_cnt + BIT_W'(1);
               pend    <= 1'b1;
               unique case (st)
                  ST_HDR: if (bit_cnt == LAST_BIT) begin
                     addr <= rx_next[ADDR_W-1:0];
                     if (rx_next[WORD_W-1 -: CMD_W] == OP_WRITE) begin
                        st <= ST_WR;
                     end else if (rx_next[WORD_W-1 -: CMD_W] == OP_READ) begin
                        st       <= ST_RD_PAD;
                        mem_re   <= 1'b1;
                        mem_addr <= rx_next[ADDR_W-1:0];
                        addr     <= rx_next[ADDR_W-1:0] + ADDR_W'(1);
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
                  ST_WR: if (bit_cnt == LAST_BIT) begin
                     mem_we    <= 1'b1;
                     mem_addr  <= addr;
                     mem_wdata <= rx_next;
                     addr      <= addr + ADDR_W'(1);
                     words     <= words + CNT_W'(1);
                  end
                  ST_RD_PAD: if (bit_cnt == PAD_LAST) begin
                     st      <= ST_RD;
                     bit_cnt <= '0;
                     load    <= 1'b1;
                  end
                  ST_RD: if (bit_cnt == LAST_BIT) begin
                     words <= words + CNT_W'(1);
                     load  <= 1'b1;
                  end
                  default: ;
               endcase
            end
            if (shf && pend) begin
               pend <= 1'b0;
               if (load) begin
                  load     <= 1'b0;
                  tx_sh    <= tx_buf;
                  mem_re   <= 1'b1;
                  mem_addr <= addr;
                  addr     <= addr + ADDR_W'(1);
               end else begin
                  tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge
   import spi_mem_bridge_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DUMMY_BITS  = 8,
   parameter int CNT_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        spi_mode,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              xfer_done,
   output logic [CNT_W-1:0]  xfer_words
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DUMMY_BITS < 1 || DUMMY_BITS > WORD_W) begin : g_bad_pad
      $error("DUMMY_BITS must lie in 1..WORD_W");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end

   logic cs_act, cs_end, smp, shf, mosi_s;

   spi_mem_bridge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode),
      .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
      .cs_act(cs_act), .cs_end(cs_end), .smp(smp), .shf(shf), .mosi_s(mosi_s)
   );

   spi_mem_bridge_core #(.DUMMY_BITS(DUMMY_BITS), .CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_end(cs_end),
      .smp(smp), .shf(shf), .mosi_s(mosi_s), .miso(spi_miso),
      .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .done(xfer_done), .done_words(xfer_words)
   );
endmodule

// File: rtl/spi_mem_bridge_chk.sv
module spi_mem_bridge_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_act,
   input logic miso,
   input logic mem_we,
   input logic mem_re,
   input logic xfer_done
);
   assert_idle_miso_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !miso);
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);
   assert_port_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
   assert_write_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(cs_act));
   assert_read_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> $past(cs_act));
endmodule

bind spi_mem_bridge spi_mem_bridge_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .miso(spi_miso),
   .mem_we(mem_we), .mem_re(mem_re), .xfer_done(xfer_done)
);

// File: tb/spi_mem_bridge_tb.sv
module spi_mem_bridge_tb;
   localparam int HALF = 8;
   localparam int PAD  = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  spi_mode;
   logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;
   logic        mem_we, mem_re;
   logic [27:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic        xfer_done;
   logic [15:0] xfer_words;

   always #5 clk = ~clk;

   spi_mem_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .spi_sclk(spi_sclk),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .xfer_done(xfer_done), .xfer_words(xfer_words)
   );

   logic [31:0] bmem [0:255];
   always @(posedge clk) begin
      if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= bmem[mem_addr[7:0]];
   end

   int n_chk = 0, n_fail = 0;
   bit tx_bits[$];
   bit rx_bits[$];
   logic [59:0] exp_wr[$];
   int exp_done[$];
   logic [31:0] shadow [int];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   function automatic logic [31:0] pat(input logic [27:0] a, input int k);
      return {a[7:0], 8'hC3, 8'(k * 37 + 5), ~a[7:0]};
   endfunction

   // scoreboard monitor: writes and done pulses
   always @(negedge clk) begin : mon
      logic [59:0] e;
      int d;
      if (rst_n === 1'b1) begin
         if (mem_we) begin
            if (exp_wr.size() == 0)
               chk(1'b0, "R5/R3", "unexpected write", 64'({mem_addr, mem_wdata}), 64'd0);
            else begin
               e = exp_wr.pop_front();
               chk({mem_addr, mem_wdata} == e, "R2", "write addr/data",
                   64'({mem_addr, mem_wdata}), 64'(e));
            end
         end
         if (xfer_done) begin
            if (exp_done.size() == 0)
               chk(1'b0, "R5", "unexpected done", 64'(xfer_words), 64'd0);
            else begin
               d = exp_done.pop_front();
               chk(xfer_words == 16'(d), "R11", "word count", 64'(xfer_words), 64'(d));
            end
         end
      end
   end

   task automatic half_bit();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic put_bits(input logic [31:0] w, input int n);
      for (int i = 31; i > 31 - n; i--) tx_bits.push_back(w[i]);
   endtask

   task automatic spi_run(input logic [1:0] mode);
      @(negedge clk);
      spi_mode = mode;
      spi_sclk = mode[1];
      repeat (6) @(negedge clk);
      spi_cs_n = 1'b0;
      rx_bits.delete();
      half_bit();
      foreach (tx_bits[i]) begin
         if (!mode[0]) begin
            spi_mosi = tx_bits[i];
            half_bit();
            spi_sclk = ~mode[1];
            rx_bits.push_back(spi_miso);
            half_bit();
            spi_sclk = mode[1];
         end else begin
            spi_sclk = ~mode[1];
            spi_mosi = tx_bits[i];
            half_bit();
            spi_sclk = mode[1];
            rx_bits.push_back(spi_miso);
            half_bit();
         end
      end
      half_bit();
      spi_cs_n = 1'b1;
      spi_mosi = 1'b0;
      repeat (10) @(negedge clk);
      chk(spi_miso == 1'b0, "R7", "miso idle with cs high", 64'(spi_miso), 64'd0);
   endtask

   task automatic wr_txn(input logic [1:0] mode, input logic [27:0] a, input int n, input int extra);
      logic [31:0] w;
      tx_bits.delete();
      put_bits({4'h5, a}, 32);
      for (int k = 0; k < n; k++) begin
         w = pat(a + 28'(k), k);
         put_bits(w, 32);
         exp_wr.push_back({a + 28'(k), w});
         shadow[int'(a + 28'(k))] = w;
      end
      if (extra > 0) put_bits(32'hFFFF_FFFF, extra);   // R3 trailing partial word
      exp_done.push_back(n);
      spi_run(mode);
   endtask

   task automatic rd_txn(input logic [1:0] mode, input logic [27:0] a, input int n, input int extra);
      logic [31:0] got;
      int zeros;
      tx_bits.delete();
      put_bits({4'h4, a}, 32);
      for (int k = 0; k < n * 32 + PAD + extra; k++) tx_bits.push_back(1'b1);
      exp_done.push_back(n);
      spi_run(mode);
      zeros = 0;
      for (int i = 0; i < 32 + PAD; i++) zeros += int'(rx_bits[i]);
      chk(zeros == 0, "R4", "header and dummy bits zero", 64'(zeros), 64'd0);
      for (int k = 0; k < n; k++) begin
         got = '0;
         for (int b = 0; b < 32; b++) got = {got[30:0], rx_bits[32 + PAD + 32 * k + b]};
         chk(got == shadow[int'(a + 28'(k))], "R4/R8", "read word", 64'(got),
             64'(shadow[int'(a + 28'(k))]));
      end
   endtask

   task automatic raw_txn(input logic [1:0] mode, input logic [31:0] hdr, input int hbits,
                          input int nbits, input string req);
      int ones;
      tx_bits.delete();
      put_bits(hdr, hbits);
      for (int k = 0; k < nbits; k++) tx_bits.push_back(1'b1);
      spi_run(mode);
      ones = 0;
      foreach (rx_bits[i]) ones += int'(rx_bits[i]);
      chk(ones == 0, req, "miso stays zero", 64'(ones), 64'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog expired: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; spi_mode = 2'b00; spi_sclk = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(spi_miso == 1'b0, "R7", "reset miso", 64'(spi_miso), 64'd0);
      chk(xfer_done == 1'b0, "R9", "reset done", 64'(xfer_done), 64'd0);
      chk(mem_we == 1'b0 && mem_re == 1'b0, "R10", "reset strobes", 64'({mem_we, mem_re}), 64'd0);

      // R1 R2 mode 0 write then read back
      wr_txn(2'b00, 28'h000_0010, 3, 0);
      rd_txn(2'b00, 28'h000_0010, 3, 0);
      // R3 partial trailing word, R8 mode 1
      wr_txn(2'b01, 28'h000_0020, 2, 20);
      rd_txn(2'b01, 28'h000_0020, 2, 0);
      // R8 modes 2 and 3, R11 partial read word not counted
      wr_txn(2'b10, 28'h000_0030, 2, 0);
      rd_txn(2'b11, 28'h000_0030, 2, 10);
      // R1 wide address bits
      wr_txn(2'b11, 28'h9A5_0070, 1, 0);
      rd_txn(2'b10, 28'h9A5_0070, 1, 0);
      // R5 unknown command 7 aimed at 0x10 carries two words
      raw_txn(2'b00, {4'h7, 28'h000_0010}, 32, 64, "R5");
      rd_txn(2'b00, 28'h000_0010, 1, 0);
      // R6 R7 read aborted inside first data word, then no stale data
      tx_bits.delete();
      put_bits({4'h4, 28'h000_0020}, 32);
      for (int k = 0; k < PAD + 10; k++) tx_bits.push_back(1'b0);
      exp_done.push_back(0);
      spi_run(2'b01);
      raw_txn(2'b01, 32'h0000_0000, 32, 64, "R7");
      // R6 write aborted in header, then a clean write realigns
      raw_txn(2'b00, {4'h5, 28'h000_0040}, 17, 0, "R6");
      wr_txn(2'b00, 28'h000_0050, 1, 0);
      rd_txn(2'b00, 28'h000_0050, 1, 0);
      // R6 R9 write aborted mid second word keeps only the first
      tx_bits.delete();
      put_bits({4'h5, 28'h000_0060}, 32);
      put_bits(pat(28'h000_0060, 0), 32);
      put_bits(32'h1234_5678, 12);
      exp_wr.push_back({28'h000_0060, pat(28'h000_0060, 0)});
      shadow[32'h60] = pat(28'h000_0060, 0);
      exp_done.push_back(1);
      spi_run(2'b10);
      rd_txn(2'b10, 28'h000_0060, 1, 0);

      repeat (20) @(negedge clk);
      chk(exp_wr.size() == 0, "R2", "all writes seen", 64'(exp_wr.size()), 64'd0);
      chk(exp_done.size() == 0, "R9", "all done pulses seen", 64'(exp_done.size()), 64'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule